// File: doc/BRIEF.md
# Serial mouse packet encoder

This block turns one pointer event (a signed horizontal step, a signed vertical step and the state of three buttons) into a five-byte packet for a serial mouse byte stream. The event arrives on a valid/ready handshake. While a packet is going out, the event side reports not ready, so one packet can never mix with the event that follows it.

The header byte carries the buttons active-low under a fixed marker pattern. The two motion bytes hold the steps saturated to the symmetric range -127..+127 in 8-bit two's complement. The vertical step is negated before it is saturated. Two zero bytes close every packet. Bytes leave on a valid/ready output meant for an external receive FIFO. A byte advances only on a completed output handshake.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset `out_valid` is 0 and `ev_ready` is 1.
- R2: `ev_ready` is 0 from the cycle after an event is accepted (`ev_valid` and `ev_ready` both high at a rising edge) until the last byte of its packet has been taken. Event inputs presented during that time are ignored, and the packet in flight keeps its bytes.
- R3: Byte 0 is 0x87 with bit 2 cleared when `ev_btn[2]` (left) is 1, bit 1 cleared when `ev_btn[1]` (middle) is 1 and bit 0 cleared when `ev_btn[0]` (right) is 1.
- R4: Byte 1 is `ev_dx`, read as a 10-bit two's complement value and clamped to -127..+127 before truncation to 8 bits (so -512 gives 0x81, 511 gives 0x7F, and 0x80 never appears).
- R5: Byte 2 is the negation of `ev_dy` (10-bit two's complement), clamped to -127..+127 and then truncated (so `ev_dy` = -512 or -128 gives 0x7F, and 127 gives 0x81).
- R6: Bytes 3 and 4 are always 0x00.
- R7: Bytes go out in the order 0 to 4. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. Each completed output handshake moves on by exactly one byte.
- R8: In the cycle after byte 4 is taken, `out_valid` is 0 and `ev_ready` is 1. A packet therefore has exactly five bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Encoder idle, an event can be accepted |
| ev_dx | input | MOT_W | Horizontal step, two's complement |
| ev_dy | input | MOT_W | Vertical step, two's complement |
| ev_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| out_valid | output | 1 | Packet byte present |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Packet byte |

## Verification
On every cycle the assertions check the following: the output holds during stalls, the byte index advances one step per handshake, the stream stops after the fifth byte, an accepted event starts at byte 0, the header keeps its marker bits, the motion bytes never carry the excluded value 0x80, and the trailing bytes are zero. Only the bench scenarios can show the numeric mapping. That covers the exact button clearing, the saturation points at ±127 and at the 10-bit extremes, and the negation of the vertical step. They also show that events offered during a packet leave its bytes unchanged. The bench does this by comparing every emitted byte with values it computes itself, under random stalls on the output side.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int BYTE_W = 8;
  localparam int HEAD_BYTES = 3;
  localparam logic [BYTE_W-1:0] HEAD_IDLE = 8'h87;
  localparam int MOT_LIM = 127;

  typedef logic [BYTE_W-1:0] byte_t;

  // Header byte: buttons are active low in the three lowest bits.
  function automatic byte_t head_byte(input logic [2:0] pressed);
    byte_t b;
    b = HEAD_IDLE;
    b[2] = ~pressed[2];
    b[1] = ~pressed[1];
    b[0] = ~pressed[0];
    return b;
  endfunction

  // Symmetric saturation of a wide signed value, then truncation.
  function automatic byte_t sat_byte(input logic signed [31:0] v);
    logic signed [31:0] c;
    if (v > MOT_LIM) c = MOT_LIM;
    else if (v < -MOT_LIM) c = -MOT_LIM;
    else c = v;
    return c[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/mpk_shape.sv
module mpk_shape #(
  parameter int MOT_W = 10
) (
  input  logic [MOT_W-1:0] dx,
  input  logic [MOT_W-1:0] dy,
  input  logic [2:0]       btn,
  output mpk_pkg::byte_t   head_b,
  output mpk_pkg::byte_t   x_b,
  output mpk_pkg::byte_t   y_b
);
  import mpk_pkg::*;
  localparam int EXT_W = 32 - MOT_W;

  logic signed [31:0] dx_ext;
  logic signed [31:0] dy_ext;
  logic signed [31:0] dy_neg;

  always_comb begin
    dx_ext = {{EXT_W{dx[MOT_W-1]}}, dx};
    dy_ext = {{EXT_W{dy[MOT_W-1]}}, dy};
    dy_neg = -dy_ext;
    head_b = head_byte(btn);
    x_b    = sat_byte(dx_ext);
    y_b    = sat_byte(dy_neg);
  end
endmodule

// File: rtl/mpk_hold.sv
module mpk_hold (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  mpk_pkg::byte_t head_in,
  input  mpk_pkg::byte_t x_in,
  input  mpk_pkg::byte_t y_in,
  output mpk_pkg::byte_t head_q,
  output mpk_pkg::byte_t x_q,
  output mpk_pkg::byte_t y_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= mpk_pkg::HEAD_IDLE;
      x_q    <= '0;
      y_q    <= '0;
    end else if (load) begin
      head_q <= head_in;
      x_q    <= x_in;
      y_q    <= y_in;
    end
  end
endmodule

// File: rtl/mpk_seq.sv
module mpk_seq #(
  parameter int PKT_LEN = 5,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             out_ready,
  output logic             ev_ready,
  output logic             busy,
  output logic             take,
  output logic             fire,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic busy_q;
  logic [IDX_W-1:0] idx_q;

  assign ev_ready = ~busy_q;
  assign busy     = busy_q;
  assign idx      = idx_q;
  assign take     = ev_valid & ~busy_q;
  assign fire     = busy_q & out_ready;
  assign done     = fire & (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (fire) begin
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc #(
  parameter int MOT_W = 10,
  parameter int TAIL_BYTES = 2,
  localparam int PKT_LEN = mpk_pkg::HEAD_BYTES + TAIL_BYTES,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [MOT_W-1:0] ev_dx,
  input  logic [MOT_W-1:0] ev_dy,
  input  logic [2:0]       ev_btn,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  import mpk_pkg::*;

  // Named internal events, also observed by the checker.
  logic             ev_take;
  logic             byte_fire;
  logic             pkt_done;
  logic             busy;
  logic [IDX_W-1:0] byte_idx;

  byte_t head_c, x_c, y_c;
  byte_t head_q, x_q, y_q;
  byte_t slot [PKT_LEN];

  mpk_shape #(.MOT_W(MOT_W)) u_shape (
    .dx(ev_dx), .dy(ev_dy), .btn(ev_btn),
    .head_b(head_c), .x_b(x_c), .y_b(y_c)
  );

  mpk_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(ev_take),
    .head_in(head_c), .x_in(x_c), .y_in(y_c),
    .head_q(head_q), .x_q(x_q), .y_q(y_q)
  );

  mpk_seq #(.PKT_LEN(PKT_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .out_ready(out_ready),
    .ev_ready(ev_ready), .busy(busy), .take(ev_take), .fire(byte_fire),
    .done(pkt_done), .idx(byte_idx)
  );

  assign slot[0] = head_q;
  assign slot[1] = x_q;
  assign slot[2] = y_q;
  for (genvar t = HEAD_BYTES; t < PKT_LEN; t++) begin : g_tail
    assign slot[t] = '0;
  end

  assign out_valid = busy;
  assign out_data  = slot[byte_idx];
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk #(
  parameter int PKT_LEN = 5,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_take,
  input logic             pkt_done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic [IDX_W-1:0] byte_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> out_valid && byte_idx == '0); // R2
  AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> !out_valid); // R2
  AST_HEAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && byte_idx == '0 |-> out_data[7:3] == 5'b10000); // R3
  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && byte_idx == IDX_W'(1) |-> out_data != 8'h80); // R4
  AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && byte_idx == IDX_W'(2) |-> out_data != 8'h80); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && byte_idx >= IDX_W'(3) |-> out_data == 8'h00); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(byte_idx)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && byte_idx != LAST |=>
      out_valid && byte_idx == $past(byte_idx) + 1'b1); // R7
  AST_PKT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !out_valid); // R8
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_take(ev_take), .pkt_done(pkt_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .byte_idx(byte_idx)
);

// File: tb/tb_mouse_pkt_enc.sv
`timescale 1ns/1ps
module tb_mouse_pkt_enc;
  localparam int MW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic ev_valid = 0;
  logic ev_ready;
  logic [MW-1:0] ev_dx = '0;
  logic [MW-1:0] ev_dy = '0;
  logic [2:0] ev_btn = '0;
  logic out_valid;
  logic out_ready = 0;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mouse_pkt_enc dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_btn(ev_btn), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] want_head(input logic [2:0] b);
    int v;
    v = 128 + (b[2] ? 0 : 4) + (b[1] ? 0 : 2) + (b[0] ? 0 : 1);
    return v[7:0];
  endfunction

  function automatic logic [7:0] want_mot(input int v);
    int c;
    c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    if (c < 0) c = c + 256;
    return c[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_packet(input int dx, input int dy, input logic [2:0] b);
    logic [7:0] got [5];
    logic [7:0] exp [5];
    logic [7:0] held;
    bit stalled;
    int n;
    int guard;
    exp[0] = want_head(b);
    exp[1] = want_mot(dx);
    exp[2] = want_mot(-dy);
    exp[3] = 8'h00;
    exp[4] = 8'h00;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R8 idle before event", ev_ready, 1);
    ev_valid = 1;
    ev_dx = MW'(dx);
    ev_dy = MW'(dy);
    ev_btn = b;
    out_ready = 0;
    n = 0;
    stalled = 0;
    held = '0;
    guard = 0;
    while (n < 5 && guard < 200) begin
      @(negedge clk);
      guard++;
      chk(out_valid == 1'b1, "R7 valid during packet", out_valid, 1);
      chk(ev_ready == 1'b0, "R2 not ready during packet", ev_ready, 0);
      if (stalled) chk(out_data == held, "R7 hold on stall", out_data, held);
      // Garbage event while busy must be ignored (R2).
      ev_valid = 1;
      ev_dx = MW'($urandom);
      ev_dy = MW'($urandom);
      ev_btn = 3'($urandom);
      if ($urandom % 3 != 0) begin
        out_ready = 1;
        got[n] = out_data;
        n++;
        stalled = 0;
      end else begin
        out_ready = 0;
        held = out_data;
        stalled = 1;
      end
    end
    @(negedge clk);
    ev_valid = 0;
    out_ready = 0;
    chk(out_valid == 1'b0, "R8 stop after five bytes", out_valid, 0);
    chk(ev_ready == 1'b1, "R8 ready after packet", ev_ready, 1);
    chk(got[0] == exp[0], "R3 header byte", got[0], exp[0]);
    chk(got[1] == exp[1], "R4 x byte", got[1], exp[1]);
    chk(got[2] == exp[2], "R5 y byte", got[2], exp[2]);
    chk(got[3] == exp[3] && got[4] == exp[4], "R6 tail bytes",
        {got[3], got[4]}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int edge_v [10];
    void'($urandom(32'h5eed_1234));
    edge_v = '{511, -512, 127, -127, 128, -128, 126, 0, 1, -1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(ev_ready == 1'b1, "R1 reset ready", ev_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0 && ev_ready == 1'b1, "R1 after reset",
        {out_valid, ev_ready}, 1);
    for (int b = 0; b < 8; b++) run_packet(5, -3, 3'(b));         // R3
    for (int i = 0; i < 10; i++) run_packet(edge_v[i], edge_v[9 - i], 3'b000); // R4 R5
    for (int k = 0; k < 300; k++) begin
      int dx, dy;
      dx = int'($urandom % 1024) - 512;
      dy = int'($urandom % 1024) - 512;
      if ($urandom % 2 == 0) begin
        dx = dx / 4;
        dy = dy / 4;
      end
      run_packet(dx, dy, 3'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule